// File: doc/BRIEF.md
# Dual-clock ping-pong block FIFO

This block moves data between two unrelated clock domains in whole blocks instead of single words. A dual-port RAM is split into a lower and an upper half. A producer on the write clock claims a free half, streams up to one half's worth of words into it, and releases it. The block counts the words that were accepted and passes that count, together with the identity of the half, across to the read clock. Both halves can be in flight at once, so the producer can fill one half while the consumer drains the other.

On the read side the consumer watches one availability flag. It claims the oldest filled half and is told how many words that half holds. It pulls the words out one by one and then releases the half, which returns it to the write side. Neither side has to track full, empty or watermark conditions per word. Each side knows before it starts exactly how much room or data it has.

Write-side words are handed over with `wr_valid`/`wr_ready`. A word moves on a write-clock edge where both are high. `wr_ready` is low when no half is owned, when the owned half is full, and in the cycle the claim is dropped, so the producer may hold `wr_valid` high at any time without loss. Read-side words are handed over with `rd_valid`/`rd_next`. `rd_data` holds the current word while `rd_valid` is high. A rising read-clock edge with both high moves to the next word, and `rd_next` has no effect otherwise.

Top module: `pingpong_block_fifo`

## Requirements
- R1: After reset, `wr_free` is 2'b11, `wr_ready`, `rd_avail` and `rd_valid` are 0, `rd_count` is 0, and `wr_capacity` equals 2^(ADDR_W-1).
- R2: The producer claims a half by driving `wr_claim` one-hot, where bit 0 selects the lower half and bit 1 the upper half. The claim takes effect only when that half's `wr_free` bit is 1. From the next cycle that `wr_free` bit is 0 and `wr_ready` is 1.
- R3: While a half is owned, words accepted by `wr_valid && wr_ready` are stored at consecutive addresses from the start of the half. At most `wr_capacity` words are accepted. After that, `wr_ready` is 0 and further `wr_valid` has no effect.
- R4: `wr_valid` while no half is owned stores nothing and adds nothing to any block's count.
- R5: Dropping the owning `wr_claim` bit releases the half. If at least one word was accepted, the half later appears on the read side with `rd_count` equal to the number of accepted words.
- R6: Filled halves are offered to the reader in the order in which they were released by the writer.
- R7: Raising `rd_claim` while `rd_avail` is 1 takes the oldest filled half. From the next read cycle, `rd_data` shows its first word and `rd_valid` is 1. Each accepted `rd_next` advances to the next word. `rd_valid` falls after `rd_count` words.
- R8: Dropping `rd_claim` after the last word returns the half to the write side, and its `wr_free` bit becomes 1 again.
- R9: Releasing a half with zero words accepted makes it free again without ever raising `rd_avail`.
- R10: `rd_next` while `rd_valid` is 0 leaves `rd_data` and `rd_valid` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Asynchronous active-high reset for both domains |
| wr_clk | input | 1 | Write-side clock |
| wr_free | output | 2 | Per-half free flags (bit 0 lower, bit 1 upper) |
| wr_claim | input | 2 | One-hot half claim; dropping the bit releases the half |
| wr_capacity | output | 24 | Words one half can hold |
| wr_valid | input | 1 | Producer has a word on `wr_data` |
| wr_ready | output | 1 | Owned half can accept a word this cycle |
| wr_data | input | DATA_W | Word to store |
| rd_clk | input | 1 | Read-side clock |
| rd_avail | output | 1 | A filled half is waiting to be claimed |
| rd_claim | input | 1 | Take the oldest filled half; dropping it releases the half |
| rd_count | output | 24 | Valid words in the claimed half (0 when none claimed) |
| rd_valid | output | 1 | `rd_data` holds an unread word |
| rd_next | input | 1 | Advance to the next word |
| rd_data | output | DATA_W | Current word of the claimed half |

## Verification
The assertions take several things for granted about the callers. The producer holds at most one `wr_claim` bit and keeps it until it is done with the half. The reader drains every counted word before dropping `rd_claim`. Under those conditions, a half reaches the opposite domain only while its owner has let go of it. The bench keeps to these rules in every task: it claims a single half only after its `wr_free` bit is seen high, and it drops `rd_claim` only after `rd_valid` has fallen. It sweeps every block length from zero to two words beyond capacity on alternating halves, and it fills both halves before reading in either order.

// File: rtl/pbf_pkg.sv
package pbf_pkg;
  // width of the size and count outputs on both sides
  localparam int SIZE_W = 24;
endpackage

// File: rtl/pbf_xfer.sv
// Toggle handshake carrying one held word from a source clock to a destination clock.
module pbf_xfer #(
  parameter int W = 4
) (
  input  logic         rst,
  input  logic         src_clk,
  input  logic         src_send,
  input  logic [W-1:0] src_data,
  output logic         src_busy,
  input  logic         dst_clk,
  output logic         dst_pulse,
  output logic [W-1:0] dst_data
);
  logic         req_t, ack_s1, ack_s2;
  logic         req_s1, req_s2, ack_t;
  logic [W-1:0] hold;

  always_ff @(posedge src_clk or posedge rst) begin
    if (rst) begin
      req_t  <= 1'b0;
      ack_s1 <= 1'b0;
      ack_s2 <= 1'b0;
      hold   <= '0;
    end else begin
      ack_s1 <= ack_t;
      ack_s2 <= ack_s1;
      if (src_send) begin
        req_t <= ~req_t;
        hold  <= src_data;
      end
    end
  end

  always_ff @(posedge dst_clk or posedge rst) begin
    if (rst) begin
      req_s1 <= 1'b0;
      req_s2 <= 1'b0;
      ack_t  <= 1'b0;
    end else begin
      req_s1 <= req_t;
      req_s2 <= req_s1;
      ack_t  <= req_s2;
    end
  end

  assign src_busy  = req_t ^ ack_s2;
  assign dst_pulse = req_s2 ^ ack_t;
  assign dst_data  = hold;

  // R5: the carried word must not move while the other side may sample it
  assert_hold_stable_R5: assert property (@(posedge src_clk) disable iff (rst)
    src_busy |=> $stable(hold));
  // R5: a new word is only launched once the previous one is acknowledged
  assert_send_when_idle_R5: assert property (@(posedge src_clk) disable iff (rst)
    src_send |-> !src_busy);
endmodule

// File: rtl/pbf_ram.sv
// Two-clock simple dual-port memory with registered read.
module pbf_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              wr_clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_clk,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rd_clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pbf_write_side.sv
// Write-domain ownership, fill counting and ordered hand-off of filled halves.
module pbf_write_side #(
  parameter int ADDR_W = 4,
  localparam int HALF_W = ADDR_W - 1,
  localparam int CW = HALF_W + 1,
  localparam int MSG_W = CW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        claim,
  input  logic              valid,
  output logic              ready,
  output logic [1:0]        free,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              send,
  output logic [MSG_W-1:0]  msg,
  input  logic              busy,
  input  logic              ret_pulse,
  input  logic              ret_half
);
  localparam int HALF = 1 << HALF_W;
  localparam logic [CW-1:0] HALF_C = HALF[CW-1:0];

  logic          act, cur, pfirst;
  logic [CW-1:0] cnt;
  logic [1:0]    free_r, pend;
  logic [CW-1:0] pcnt [2];
  logic          take, take_h, rel, send_h;

  assign take   = !act && ((claim == 2'b01 && free_r[0]) || (claim == 2'b10 && free_r[1]));
  assign take_h = claim[1];
  assign rel    = act && !claim[cur];
  assign ready  = act && claim[cur] && (cnt < HALF_C);
  assign mem_we = valid && ready;
  assign mem_addr = {cur, cnt[HALF_W-1:0]};
  assign free   = free_r;

  assign send_h = (pend == 2'b11) ? pfirst : pend[1];
  assign send   = !busy && (pend != 2'b00);
  assign msg    = {send_h, pcnt[send_h]};

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      act    <= 1'b0;
      cur    <= 1'b0;
      cnt    <= '0;
      free_r <= 2'b11;
      pend   <= 2'b00;
      pfirst <= 1'b0;
      for (int i = 0; i < 2; i++) pcnt[i] <= '0;
    end else begin
      if (send) pend[send_h] <= 1'b0;
      if (take) begin
        act            <= 1'b1;
        cur            <= take_h;
        cnt            <= '0;
        free_r[take_h] <= 1'b0;
      end else if (act) begin
        if (mem_we) cnt <= cnt + 1'b1;
        if (rel) begin
          act <= 1'b0;
          if (cnt != '0) begin
            pend[cur] <= 1'b1;
            pcnt[cur] <= cnt;
            if (!pend[~cur]) pfirst <= cur;
          end else begin
            free_r[cur] <= 1'b1;
          end
        end
      end
      if (ret_pulse) free_r[ret_half] <= 1'b1;
    end
  end

  // R3: never more words than one half holds
  assert_fill_bound_R3: assert property (@(posedge clk) disable iff (rst)
    act |-> cnt <= HALF_C);
  // R2: an owned half is never reported free
  assert_owned_not_free_R2: assert property (@(posedge clk) disable iff (rst)
    act |-> !free_r[cur]);
  // R8: a half handed back by the reader was not already free
  assert_return_held_R8: assert property (@(posedge clk) disable iff (rst)
    ret_pulse |-> !free_r[ret_half]);
endmodule

// File: rtl/pbf_read_side.sv
// Read-domain queue of filled halves, drain sequencing and return of freed halves.
module pbf_read_side #(
  parameter int ADDR_W = 4,
  localparam int HALF_W = ADDR_W - 1,
  localparam int CW = HALF_W + 1,
  localparam int MSG_W = CW + 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      claim,
  input  logic                      next,
  output logic                      avail,
  output logic                      valid,
  output logic [pbf_pkg::SIZE_W-1:0] count,
  output logic [ADDR_W-1:0]         mem_addr,
  input  logic                      fill_pulse,
  input  logic [MSG_W-1:0]          fill_msg,
  output logic                      send,
  output logic                      ret_half,
  input  logic                      busy
);
  logic              act, cur, oldest;
  logic [1:0]        full_r, fpend;
  logic [CW-1:0]     cnt_r [2];
  logic [CW-1:0]     idx;
  logic [HALF_W-1:0] aidx;
  logic              take, rel, adv, fh;
  logic [CW-1:0]     fc;

  assign fh    = fill_msg[CW];
  assign fc    = fill_msg[CW-1:0];
  assign avail = !act && full_r[oldest];
  assign take  = claim && avail;
  assign rel   = act && !claim;
  assign valid = act && (idx < cnt_r[cur]);
  assign adv   = valid && next && claim;
  assign count = act ? {{(pbf_pkg::SIZE_W-CW){1'b0}}, cnt_r[cur]} : '0;

  always_comb begin
    aidx = idx[HALF_W-1:0];
    if (adv) aidx = idx[HALF_W-1:0] + 1'b1;
    mem_addr = take ? {oldest, {HALF_W{1'b0}}} : {cur, aidx};
  end

  assign ret_half = !fpend[0];
  assign send     = !busy && (fpend != 2'b00);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      act    <= 1'b0;
      cur    <= 1'b0;
      oldest <= 1'b0;
      idx    <= '0;
      full_r <= 2'b00;
      fpend  <= 2'b00;
      for (int i = 0; i < 2; i++) cnt_r[i] <= '0;
    end else begin
      if (send) fpend[ret_half] <= 1'b0;
      if (fill_pulse) begin
        full_r[fh] <= 1'b1;
        cnt_r[fh]  <= fc;
        if (full_r == 2'b00) oldest <= fh;
      end
      if (take) begin
        act <= 1'b1;
        cur <= oldest;
        idx <= '0;
      end else if (rel) begin
        act         <= 1'b0;
        full_r[cur] <= 1'b0;
        fpend[cur]  <= 1'b1;
        oldest      <= ~cur;
      end else if (adv) begin
        idx <= idx + 1'b1;
      end
    end
  end

  // R7: the drain position never passes the block length
  assert_drain_bound_R7: assert property (@(posedge clk) disable iff (rst)
    act |-> idx <= cnt_r[cur]);
  // R8: the claimed half stays marked filled until it is released
  assert_owned_filled_R8: assert property (@(posedge clk) disable iff (rst)
    act |-> full_r[cur]);
  // R9: empty blocks never cross to the read side
  assert_no_empty_block_R9: assert property (@(posedge clk) disable iff (rst)
    fill_pulse |-> fc != '0);
  // R6: a filled half only arrives into an empty slot
  assert_fill_into_empty_R6: assert property (@(posedge clk) disable iff (rst)
    fill_pulse |-> !full_r[fh]);
endmodule

// File: rtl/pingpong_block_fifo.sv
module pingpong_block_fifo #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic                       rst,
  input  logic                       wr_clk,
  output logic [1:0]                 wr_free,
  input  logic [1:0]                 wr_claim,
  output logic [pbf_pkg::SIZE_W-1:0] wr_capacity,
  input  logic                       wr_valid,
  output logic                       wr_ready,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       rd_clk,
  output logic                       rd_avail,
  input  logic                       rd_claim,
  output logic [pbf_pkg::SIZE_W-1:0] rd_count,
  output logic                       rd_valid,
  input  logic                       rd_next,
  output logic [DATA_W-1:0]          rd_data
);
  localparam int HALF_W = ADDR_W - 1;
  localparam int CW = HALF_W + 1;
  localparam int MSG_W = CW + 1;
  localparam int HALF = 1 << HALF_W;

  logic              mem_we;
  logic [ADDR_W-1:0] waddr, raddr;
  logic              fill_send, fill_busy, fill_pulse;
  logic [MSG_W-1:0]  fill_src, fill_dst;
  logic              ret_send, ret_busy, ret_pulse;
  logic              ret_src, ret_dst;

  assign wr_capacity = pbf_pkg::SIZE_W'(HALF);

  pbf_write_side #(.ADDR_W(ADDR_W)) u_wr (
    .clk(wr_clk), .rst(rst), .claim(wr_claim), .valid(wr_valid), .ready(wr_ready),
    .free(wr_free), .mem_we(mem_we), .mem_addr(waddr), .send(fill_send),
    .msg(fill_src), .busy(fill_busy), .ret_pulse(ret_pulse), .ret_half(ret_dst)
  );

  pbf_xfer #(.W(MSG_W)) u_fill_xfer (
    .rst(rst), .src_clk(wr_clk), .src_send(fill_send), .src_data(fill_src),
    .src_busy(fill_busy), .dst_clk(rd_clk), .dst_pulse(fill_pulse), .dst_data(fill_dst)
  );

  pbf_read_side #(.ADDR_W(ADDR_W)) u_rd (
    .clk(rd_clk), .rst(rst), .claim(rd_claim), .next(rd_next), .avail(rd_avail),
    .valid(rd_valid), .count(rd_count), .mem_addr(raddr), .fill_pulse(fill_pulse),
    .fill_msg(fill_dst), .send(ret_send), .ret_half(ret_src), .busy(ret_busy)
  );

  pbf_xfer #(.W(1)) u_ret_xfer (
    .rst(rst), .src_clk(rd_clk), .src_send(ret_send), .src_data(ret_src),
    .src_busy(ret_busy), .dst_clk(wr_clk), .dst_pulse(ret_pulse), .dst_data(ret_dst)
  );

  pbf_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .wr_clk(wr_clk), .we(mem_we), .waddr(waddr), .wdata(wr_data),
    .rd_clk(rd_clk), .raddr(raddr), .rdata(rd_data)
  );
endmodule

// File: tb/pingpong_block_fifo_test.sv
`timescale 1ns/1ps
module pingpong_block_fifo_test;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int HALF = 1 << (AW - 1);

  logic          rst = 1'b1;
  logic          wr_clk = 1'b0;
  logic          rd_clk = 1'b0;
  logic [1:0]    wr_free;
  logic [1:0]    wr_claim = 2'b00;
  logic [23:0]   wr_capacity;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [DW-1:0] wr_data = '0;
  logic          rd_avail;
  logic          rd_claim = 1'b0;
  logic [23:0]   rd_count;
  logic          rd_valid;
  logic          rd_next = 1'b0;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 wr_clk = ~wr_clk;
  always #3.5 rd_clk = ~rd_clk;

  pingpong_block_fifo #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .rst(rst), .wr_clk(wr_clk), .wr_free(wr_free), .wr_claim(wr_claim),
    .wr_capacity(wr_capacity), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_clk(rd_clk), .rd_avail(rd_avail), .rd_claim(rd_claim),
    .rd_count(rd_count), .rd_valid(rd_valid), .rd_next(rd_next), .rd_data(rd_data)
  );

  function automatic int pat(int blk, int i);
    return (blk * 37 + i * 5 + 3) & 255;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge wr_clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic write_block(int h, int n, int blk);
    while (!wr_free[h]) @(negedge wr_clk);
    wr_claim = 2'(1 << h);
    @(negedge wr_clk);
    chk(wr_free[h] == 1'b0, "R2 free bit", int'(wr_free[h]), 0);
    for (int i = 0; i < n; i++) begin
      chk(wr_ready == (i < HALF), "R3 ready", int'(wr_ready), int'(i < HALF));
      wr_valid = 1'b1;
      wr_data  = DW'(pat(blk, i));
      @(negedge wr_clk);
    end
    wr_valid = 1'b0;
    wr_claim = 2'b00;
    @(negedge wr_clk);
  endtask

  task automatic read_block(int exp, int blk, string tag);
    logic [DW-1:0] held;
    while (!rd_avail) @(negedge rd_clk);
    rd_claim = 1'b1;
    @(negedge rd_clk);
    chk(rd_count == 24'(exp), tag, int'(rd_count), exp);
    for (int i = 0; i < exp; i++) begin
      chk(rd_valid == 1'b1, "R7 valid", int'(rd_valid), 1);
      chk(rd_data == DW'(pat(blk, i)), "R7 data", int'(rd_data), pat(blk, i));
      rd_next = 1'b1;
      @(negedge rd_clk);
    end
    rd_next = 1'b0;
    chk(rd_valid == 1'b0, "R7 end", int'(rd_valid), 0);
    held = rd_data;
    rd_next = 1'b1;
    @(negedge rd_clk);
    rd_next = 1'b0;
    chk(rd_data == held && !rd_valid, "R10 stray next", int'(rd_data), int'(held));
    rd_claim = 1'b0;
    @(negedge rd_clk);
  endtask

  task automatic wait_all_free(string tag);
    int t = 0;
    while (wr_free != 2'b11 && t < 200) begin
      @(negedge wr_clk);
      t++;
    end
    chk(wr_free == 2'b11, tag, int'(wr_free), 3);
  endtask

  initial begin
    int blk = 1;
    repeat (10) @(negedge wr_clk);
    rst = 1'b0;
    @(negedge wr_clk);
    // R1 reset state
    chk(wr_free == 2'b11, "R1 free", int'(wr_free), 3);
    chk(wr_ready == 1'b0, "R1 ready", int'(wr_ready), 0);
    chk(rd_avail == 1'b0, "R1 avail", int'(rd_avail), 0);
    chk(rd_valid == 1'b0, "R1 valid", int'(rd_valid), 0);
    chk(rd_count == 24'd0, "R1 count", int'(rd_count), 0);
    chk(wr_capacity == 24'(HALF), "R1 capacity", int'(wr_capacity), HALF);

    // R4: strobes with nothing claimed
    wr_valid = 1'b1;
    wr_data  = 8'hAA;
    repeat (4) @(negedge wr_clk);
    chk(wr_ready == 1'b0, "R4 ready", int'(wr_ready), 0);
    wr_valid = 1'b0;
    write_block(0, 2, blk);
    read_block(2, blk, "R4 count unaffected");
    wait_all_free("R8 returned");
    blk++;

    // length sweep over both halves, R3 R5 R8 R9
    for (int n = 0; n <= HALF + 2; n++) begin
      write_block(n % 2, n, blk);
      if (n == 0) begin
        repeat (40) @(negedge wr_clk);
        chk(rd_avail == 1'b0, "R9 not offered", int'(rd_avail), 0);
        chk(wr_free == 2'b11, "R9 freed", int'(wr_free), 3);
      end else begin
        read_block((n < HALF) ? n : HALF, blk, "R5 count");
        wait_all_free("R8 returned");
      end
      blk++;
    end

    // R6: fill order upper then lower, and lower then upper
    write_block(1, 3, blk);
    write_block(0, 5, blk + 1);
    chk(wr_free == 2'b00, "R6 both held", int'(wr_free), 0);
    read_block(3, blk, "R6 first");
    read_block(5, blk + 1, "R6 second");
    wait_all_free("R8 returned");
    blk += 2;
    write_block(0, HALF, blk);
    write_block(1, 1, blk + 1);
    read_block(HALF, blk, "R6 first");
    read_block(1, blk + 1, "R6 second");
    wait_all_free("R8 returned");

    finish_run();
  end
endmodule